// File: doc/BRIEF.md
# Decimal Accumulator Stored-Program Processor

This block is a small multi-cycle processor built around one accumulator. It runs programs from an internal 100-word memory. Every word is a signed integer limited to -999..+999 and is held in signed binary form. An instruction word is read as a decimal number. The hundreds digit selects the operation. The remaining two digits give either a memory address or an I/O selector.

Before a run, a host fills the memory through a preload write port and then pulses `start`. The processor then fetches, decodes and executes instructions one at a time, and each phase takes one clock. Input and output values move over valid/ready handshakes, and the processor waits on them as long as needed. The run ends in one of two ways:
- a halt instruction, or an external halt request, leaves the processor halted;
- an error stops it in an error state that reports one of three fatal causes.

A further `start` begins a fresh run from address 00.

Top module: `decacc_cpu`

## Requirements
- R1: After reset the block is idle. `running`, `halted`, `errCode` (0) and `instrCount` (0) are all low, and `inReady` and `outValid` stay low whenever the block is not running.
- R2: A `start` pulse while the block is idle, halted or in error does the following: it clears the accumulator, the instruction counter and the error code, sets the program counter to 00 and begins fetching. A new run after an error reports `errCode` 0.
- R3: Code 5nn loads word nn into the accumulator. Code 1nn adds word nn to the accumulator and 2nn subtracts word nn from it. Memory is unchanged, and negative results are kept exactly.
- R4: Code 3nn stores the accumulator into word nn. The accumulator keeps its value.
- R5: Code 6nn always jumps to nn. Code 7nn jumps only when the accumulator is zero, and 8nn jumps only when it is zero or positive. Otherwise the program counter advances by one.
- R6: Code 901 raises `inReady` and waits until `inValid`. It then takes `inData` into the accumulator.
- R7: Code 902 raises `outValid` with `outData` equal to the accumulator. Both hold steady until `outReady`, and the accumulator is unchanged.
- R8: Any code 0nn ends the run. `halted` goes high and `running` goes low.
- R9: An accumulator value outside -999..+999 gives `errCode` 01 and stops the run without writing the accumulator. This covers add, subtract and load results and accepted input.
- R10: An instruction that would advance the program counter past 99 gives `errCode` 10 and stops the run. The instruction's own effect has already taken place.
- R11: A fetched word that is negative, above 999, 900 or 903..999 gives `errCode` 11 and stops the run.
- R12: `instrCount` counts every completed instruction, halt included. An instruction that ends in an error is not counted, and the count holds while an instruction is stalled.
- R13: Preload writes (`loadEn`) go to memory only while the block is not running. While it runs they have no effect.
- R14: `haltReq` high at an instruction boundary stops the run with `halted` high and `errCode` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run from address 00 |
| haltReq | input | 1 | Stop the run at the next instruction boundary |
| loadEn | input | 1 | Preload write enable |
| loadAddr | input | 7 | Preload word address (0..99) |
| loadData | input | 11 | Preload word, signed |
| inValid | input | 1 | Input value offered |
| inData | input | 12 | Input value, signed |
| inReady | output | 1 | Processor waits for an input value |
| outValid | output | 1 | Output value offered |
| outReady | input | 1 | Consumer accepts the output value |
| outData | output | 11 | Output value (the accumulator), signed |
| running | output | 1 | A run is in progress |
| halted | output | 1 | Run ended by halt code or halt request |
| errCode | output | 2 | 00 none, 01 data range, 10 program counter range, 11 undefined code |
| instrCount | output | 16 | Instructions completed in this run |

## Verification
The checker relies on an environment that never lets the instruction counter wrap within one run. It also relies on `start` being pulsed only while the block is stopped. The bench keeps every run to a few dozen instructions and pulses `start` only after it has seen halted or an error. The checker also treats a consumer that holds `outReady` low as legal. The bench therefore withholds `outReady` and `inValid` for many cycles on purpose, and it changes every input half a cycle away from the sampling edge.

// File: rtl/decacc_pkg.sv
package decacc_pkg;

  typedef enum logic [3:0] {
    OP_HALT, OP_ADD, OP_SUB, OP_STO, OP_NOP, OP_LDA,
    OP_JMP, OP_BRZ, OP_BRP, OP_INP, OP_OUT, OP_BAD
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_EXEC, S_HALT, S_ERR
  } state_e;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'b00,
    ERR_DATA  = 2'b01,
    ERR_PC    = 2'b10,
    ERR_UNDEF = 2'b11
  } err_e;

  typedef enum logic [1:0] {
    ACC_MEM, ACC_ADD, ACC_SUB, ACC_IN
  } acc_sel_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic     clrRun;
    logic     irLoad;
    logic     opRead;
    logic     accWe;
    acc_sel_e accSel;
    logic     memWrite;
    logic     loadOk;
    logic     pcInc;
    logic     pcJump;
    logic     cntInc;
  } strobe_t;

endpackage

// File: rtl/decacc_dpath.sv
module decacc_dpath
  import decacc_pkg::*;
#(
  parameter int WORD_W = 11,
  parameter int IN_W   = 12,
  parameter int DEPTH  = 100,
  parameter int CNT_W  = 16,
  parameter int LIMIT  = 999,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  strb,
  input  logic                     loadEn,
  input  logic [ADDR_W-1:0]        loadAddr,
  input  logic signed [WORD_W-1:0] loadData,
  input  logic signed [IN_W-1:0]   inData,
  output op_e                      decOp,
  output op_e                      irOp,
  output logic                     accZero,
  output logic                     accNeg,
  output logic                     accNextBad,
  output logic                     pcAtEnd,
  output logic signed [WORD_W-1:0] outData,
  output logic [CNT_W-1:0]         instrCount
);

  localparam int ACC_W = (WORD_W + 1 > IN_W) ? WORD_W + 1 : IN_W;

  logic signed [WORD_W-1:0] mem [DEPTH];
  logic signed [WORD_W-1:0] memRdata;
  logic signed [WORD_W-1:0] acc;
  logic [ADDR_W-1:0]        pc;
  logic [ADDR_W-1:0]        rdAddr;
  logic [ADDR_W-1:0]        decArg;
  logic [ADDR_W-1:0]        irArg;
  logic                     memWe;
  logic [ADDR_W-1:0]        memWAddr;
  logic signed [WORD_W-1:0] memWData;
  logic signed [ACC_W-1:0]  memX;
  logic signed [ACC_W-1:0]  accX;
  logic signed [ACC_W-1:0]  inX;
  logic signed [ACC_W-1:0]  accNext;

  // decimal split of the word just read
  always_comb begin
    int w;
    int hund;
    int rest;
    decOp  = OP_BAD;
    decArg = '0;
    w      = int'($unsigned(memRdata));
    hund   = w / 100;
    rest   = w % 100;
    if (!memRdata[WORD_W-1]) begin
      decArg = ADDR_W'(rest);
      case (hund)
        0:       decOp = OP_HALT;
        1:       decOp = OP_ADD;
        2:       decOp = OP_SUB;
        3:       decOp = OP_STO;
        4:       decOp = OP_NOP;
        5:       decOp = OP_LDA;
        6:       decOp = OP_JMP;
        7:       decOp = OP_BRZ;
        8:       decOp = OP_BRP;
        9:       decOp = (rest == 1) ? OP_INP : (rest == 2) ? OP_OUT : OP_BAD;
        default: decOp = OP_BAD;
      endcase
    end
  end

  assign rdAddr   = strb.opRead ? decArg : pc;
  assign memWe    = strb.memWrite | (strb.loadOk & loadEn & (int'(loadAddr) < DEPTH));
  assign memWAddr = strb.memWrite ? irArg : loadAddr;
  assign memWData = strb.memWrite ? acc : loadData;

  always_ff @(posedge clk) begin
    if (memWe) mem[memWAddr] <= memWData;
    memRdata <= mem[rdAddr];
  end

  assign memX = ACC_W'(memRdata);
  assign accX = ACC_W'(acc);
  assign inX  = ACC_W'(inData);

  always_comb begin
    case (strb.accSel)
      ACC_ADD: accNext = accX + memX;
      ACC_SUB: accNext = accX - memX;
      ACC_IN:  accNext = inX;
      default: accNext = memX;
    endcase
  end

  assign accNextBad = (accNext > LIMIT) || (accNext < -LIMIT);
  assign accZero    = (acc == '0);
  assign accNeg     = acc[WORD_W-1];
  assign pcAtEnd    = (pc == ADDR_W'(DEPTH - 1));
  assign outData    = acc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc        <= '0;
      pc         <= '0;
      irOp       <= OP_HALT;
      irArg      <= '0;
      instrCount <= '0;
    end else begin
      if (strb.clrRun) begin
        acc        <= '0;
        pc         <= '0;
        instrCount <= '0;
      end else begin
        if (strb.accWe)  acc        <= accNext[WORD_W-1:0];
        if (strb.pcJump) pc         <= irArg;
        else if (strb.pcInc) pc     <= pc + 1'b1;
        if (strb.cntInc) instrCount <= instrCount + 1'b1;
      end
      if (strb.irLoad) begin
        irOp  <= decOp;
        irArg <= decArg;
      end
    end
  end

endmodule

// File: rtl/decacc_ctrl.sv
module decacc_ctrl
  import decacc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    haltReq,
  input  logic    inValid,
  input  logic    outReady,
  input  op_e     decOp,
  input  op_e     irOp,
  input  logic    accZero,
  input  logic    accNeg,
  input  logic    accNextBad,
  input  logic    pcAtEnd,
  output strobe_t strb,
  output logic    inReady,
  output logic    outValid,
  output logic    running,
  output logic    halted,
  output err_e    errCode
);

  state_e stateQ, stateNxt;
  err_e   errQ, errNxt;

  always_comb begin
    logic advance;
    logic jump;
    logic fault;
    err_e faultCode;
    strb      = '0;
    stateNxt  = stateQ;
    errNxt    = errQ;
    inReady   = 1'b0;
    outValid  = 1'b0;
    advance   = 1'b0;
    jump      = 1'b0;
    fault     = 1'b0;
    faultCode = ERR_NONE;

    strb.loadOk = !(stateQ inside {S_FETCH, S_DECODE, S_EXEC});
    case (irOp)
      OP_ADD:  strb.accSel = ACC_ADD;
      OP_SUB:  strb.accSel = ACC_SUB;
      OP_INP:  strb.accSel = ACC_IN;
      default: strb.accSel = ACC_MEM;
    endcase

    case (stateQ)
      S_FETCH: stateNxt = haltReq ? S_HALT : S_DECODE;
      S_DECODE: begin
        strb.opRead = 1'b1;
        if (decOp == OP_BAD) begin
          fault     = 1'b1;
          faultCode = ERR_UNDEF;
        end else begin
          strb.irLoad = 1'b1;
          stateNxt    = S_EXEC;
        end
      end
      S_EXEC: begin
        case (irOp)
          OP_ADD, OP_SUB, OP_LDA: begin
            if (accNextBad) begin
              fault     = 1'b1;
              faultCode = ERR_DATA;
            end else begin
              strb.accWe = 1'b1;
              advance    = 1'b1;
            end
          end
          OP_STO: begin
            strb.memWrite = 1'b1;
            advance       = 1'b1;
          end
          OP_NOP: advance = 1'b1;
          OP_JMP: jump = 1'b1;
          OP_BRZ: if (accZero) jump = 1'b1; else advance = 1'b1;
          OP_BRP: if (!accNeg) jump = 1'b1; else advance = 1'b1;
          OP_INP: begin
            inReady = 1'b1;
            if (inValid) begin
              if (accNextBad) begin
                fault     = 1'b1;
                faultCode = ERR_DATA;
              end else begin
                strb.accWe = 1'b1;
                advance    = 1'b1;
              end
            end
          end
          OP_OUT: begin
            outValid = 1'b1;
            if (outReady) advance = 1'b1;
          end
          OP_HALT: begin
            strb.cntInc = 1'b1;
            stateNxt    = S_HALT;
          end
          default: begin
            fault     = 1'b1;
            faultCode = ERR_UNDEF;
          end
        endcase
        if (jump) begin
          strb.pcJump = 1'b1;
          strb.cntInc = 1'b1;
          stateNxt    = S_FETCH;
        end
        if (advance) begin
          if (pcAtEnd) begin
            fault     = 1'b1;
            faultCode = ERR_PC;
          end else begin
            strb.pcInc  = 1'b1;
            strb.cntInc = 1'b1;
            stateNxt    = S_FETCH;
          end
        end
      end
      default: begin
        if (start) begin
          strb.clrRun = 1'b1;
          errNxt      = ERR_NONE;
          stateNxt    = S_FETCH;
        end
      end
    endcase

    if (fault) begin
      errNxt   = faultCode;
      stateNxt = S_ERR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      errQ   <= ERR_NONE;
    end else begin
      stateQ <= stateNxt;
      errQ   <= errNxt;
    end
  end

  assign running = stateQ inside {S_FETCH, S_DECODE, S_EXEC};
  assign halted  = (stateQ == S_HALT);
  assign errCode = errQ;

endmodule

// File: rtl/decacc_cpu.sv
module decacc_cpu
  import decacc_pkg::*;
#(
  parameter int WORD_W = 11,
  parameter int IN_W   = 12,
  parameter int DEPTH  = 100,
  parameter int CNT_W  = 16,
  parameter int LIMIT  = 999,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic                     haltReq,
  input  logic                     loadEn,
  input  logic [ADDR_W-1:0]        loadAddr,
  input  logic signed [WORD_W-1:0] loadData,
  input  logic                     inValid,
  input  logic signed [IN_W-1:0]   inData,
  output logic                     inReady,
  output logic                     outValid,
  input  logic                     outReady,
  output logic signed [WORD_W-1:0] outData,
  output logic                     running,
  output logic                     halted,
  output logic [1:0]               errCode,
  output logic [CNT_W-1:0]         instrCount
);

  strobe_t strb;
  op_e     decOp;
  op_e     irOp;
  logic    accZero;
  logic    accNeg;
  logic    accNextBad;
  logic    pcAtEnd;
  err_e    errState;

  decacc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .haltReq    (haltReq),
    .inValid    (inValid),
    .outReady   (outReady),
    .decOp      (decOp),
    .irOp       (irOp),
    .accZero    (accZero),
    .accNeg     (accNeg),
    .accNextBad (accNextBad),
    .pcAtEnd    (pcAtEnd),
    .strb       (strb),
    .inReady    (inReady),
    .outValid   (outValid),
    .running    (running),
    .halted     (halted),
    .errCode    (errState)
  );

  decacc_dpath #(
    .WORD_W (WORD_W),
    .IN_W   (IN_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W),
    .LIMIT  (LIMIT)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .loadEn     (loadEn),
    .loadAddr   (loadAddr),
    .loadData   (loadData),
    .inData     (inData),
    .decOp      (decOp),
    .irOp       (irOp),
    .accZero    (accZero),
    .accNeg     (accNeg),
    .accNextBad (accNextBad),
    .pcAtEnd    (pcAtEnd),
    .outData    (outData),
    .instrCount (instrCount)
  );

  assign errCode = errState;

endmodule

// File: rtl/decacc_chk.sv
module decacc_chk #(
  parameter int WORD_W = 11,
  parameter int CNT_W  = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     running,
  input logic                     halted,
  input logic [1:0]               errCode,
  input logic                     inReady,
  input logic                     inValid,
  input logic                     outValid,
  input logic                     outReady,
  input logic signed [WORD_W-1:0] outData,
  input logic [CNT_W-1:0]         instrCount
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!inReady && !outValid));

  a_r8_halt_clean: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> (!running && errCode == 2'b00));

  a_r9_err_stopped: assert property (@(posedge clk) disable iff (!rstN)
    (errCode != 2'b00) |-> (!running && !halted));

  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  a_r6_in_wait: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !inValid) |=> inReady);

  a_r12_stall_count: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(instrCount));

  a_r12_count_step: assert property (@(posedge clk) disable iff (!rstN)
    running |=> (instrCount == $past(instrCount)) ||
                (instrCount == CNT_W'($past(instrCount) + 1'b1)));

endmodule

bind decacc_cpu decacc_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .running    (running),
  .halted     (halted),
  .errCode    (errCode),
  .inReady    (inReady),
  .inValid    (inValid),
  .outValid   (outValid),
  .outReady   (outReady),
  .outData    (outData),
  .instrCount (instrCount)
);

// File: tb/sim_decacc_cpu.sv
module sim_decacc_cpu;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                start = 1'b0;
  logic                haltReq = 1'b0;
  logic                loadEn = 1'b0;
  logic [6:0]          loadAddr = '0;
  logic signed [10:0]  loadData = '0;
  logic                inValid = 1'b0;
  logic signed [11:0]  inData = '0;
  logic                inReady;
  logic                outValid;
  logic                outReady = 1'b1;
  logic signed [10:0]  outData;
  logic                running;
  logic                halted;
  logic [1:0]          errCode;
  logic [15:0]         instrCount;

  decacc_cpu u0 (
    .clk(clk), .rstN(rstN), .start(start), .haltReq(haltReq),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .running(running), .halted(halted), .errCode(errCode),
    .instrCount(instrCount)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int inQ[8];
  int inCnt = 0;
  int inIdx = 0;
  bit inEnable = 1'b1;
  bit inTook = 1'b0;
  int outQ[8];
  int outN = 0;

  // input source and output sink, updated 1 ns after each falling edge
  always @(negedge clk) begin
    #1;
    if (inTook) inIdx++;
    inValid = inEnable && (inIdx < inCnt);
    inData  = (inIdx < inCnt && inIdx < 8) ? 12'(inQ[inIdx]) : 12'sd0;
    inTook  = inValid && inReady;
    if (outValid && outReady && outN < 8) begin
      outQ[outN] = int'(outData);
      outN++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic poke(int a, int v);
    @(negedge clk);
    loadEn   = 1'b1;
    loadAddr = 7'(a);
    loadData = 11'(v);
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic prep();
    @(negedge clk);
    loadEn = 1'b1;
    for (int a = 0; a < 100; a++) begin
      loadAddr = 7'(a);
      loadData = '0;
      @(negedge clk);
    end
    loadEn   = 1'b0;
    inCnt    = 0;
    inIdx    = 0;
    outN     = 0;
    inEnable = 1'b1;
    outReady = 1'b1;
  endtask

  task automatic startRun();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!halted && errCode == 2'b00 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk("run finished (timeout)", int'(n < 3000), 1);
  endtask

  task automatic t_reset();
    chk("R1 running", int'(running), 0);
    chk("R1 halted", int'(halted), 0);
    chk("R1 errCode", int'(errCode), 0);
    chk("R1 instrCount", int'(instrCount), 0);
    chk("R1 handshakes", int'(inReady | outValid), 0);
  endtask

  // in, store, in, add, out, halt
  task automatic t_add();
    prep();
    poke(0, 901); poke(1, 399); poke(2, 901); poke(3, 199); poke(4, 902); poke(5, 0);
    inQ[0] = 12; inQ[1] = 30; inCnt = 2;
    startRun();
    waitDone();
    chk("R3 R6 sum out", outQ[0], 42);
    chk("R7 one output", outN, 1);
    chk("R8 halted", int'(halted), 1);
    chk("R8 not running", int'(running), 0);
    chk("R12 count add prog", int'(instrCount), 6);
    chk("R2 err clear", int'(errCode), 0);
  endtask

  task automatic t_diff(int a, int b, int expCount);
    prep();
    poke(0, 901); poke(1, 310); poke(2, 901); poke(3, 311); poke(4, 210);
    poke(5, 808); poke(6, 510); poke(7, 211); poke(8, 902); poke(9, 0);
    inQ[0] = a; inQ[1] = b; inCnt = 2;
    startRun();
    waitDone();
    chk("R5 BRP diff result", outQ[0], (b > a) ? b - a : a - b);
    chk("R12 R5 diff count", int'(instrCount), expCount);
  endtask

  task automatic t_branch();
    prep();
    poke(0, 510); poke(1, 704); poke(2, 902); poke(3, 0); poke(4, 511);
    poke(5, 708); poke(6, 902); poke(7, 609); poke(8, 0); poke(9, 412);
    poke(10, 0); poke(11, 7);
    startRun();
    waitDone();
    chk("R5 BRZ/JMP outputs", outN, 1);
    chk("R5 BRZ/JMP value", outQ[0], 7);
    chk("R12 R5 branch count", int'(instrCount), 8);
    chk("R8 halted", int'(halted), 1);
  endtask

  task automatic t_store_neg();
    prep();
    poke(0, 510); poke(1, 312); poke(2, 902); poke(3, 512); poke(4, 902);
    poke(5, 213); poke(6, 809); poke(7, 902); poke(8, 0); poke(9, 0);
    poke(10, 25); poke(13, 1024 - 1000);
    // word 13 = 24 -> 25 - 24 = 1, BRP taken to 09 halt
    startRun();
    waitDone();
    chk("R4 acc kept after store", outQ[0], 25);
    chk("R4 stored word reloaded", outQ[1], 25);
    chk("R5 BRP taken skips out", outN, 2);
    prep();
    poke(0, 510); poke(1, 211); poke(2, 805); poke(3, 902); poke(4, 0);
    poke(10, -500); poke(11, 499);
    startRun();
    waitDone();
    chk("R3 negative sub", outQ[0], -999);
    chk("R5 BRP not taken on negative", outN, 1);
    chk("R12 neg count", int'(instrCount), 5);
  endtask

  task automatic t_data_err();
    prep();
    poke(0, 510); poke(1, 111); poke(2, 0); poke(10, 900); poke(11, 100);
    startRun();
    waitDone();
    chk("R9 add overflow code", int'(errCode), 1);
    chk("R9 not halted", int'(halted), 0);
    chk("R12 error not counted", int'(instrCount), 1);
    prep();
    poke(0, 510); poke(1, 211); poke(10, -999); poke(11, 1);
    startRun();
    waitDone();
    chk("R9 sub underflow code", int'(errCode), 1);
    prep();
    poke(0, 901);
    inQ[0] = 1000; inCnt = 1;
    startRun();
    waitDone();
    chk("R9 input range code", int'(errCode), 1);
    chk("R9 R12 input count", int'(instrCount), 0);
  endtask

  task automatic t_pc_err();
    prep();
    poke(0, 698); poke(98, 402); poke(99, 902);
    startRun();
    waitDone();
    chk("R10 pc overrun code", int'(errCode), 2);
    chk("R10 output still done", outN, 1);
    chk("R10 output value", outQ[0], 0);
    chk("R12 R10 count", int'(instrCount), 2);
  endtask

  task automatic t_undef();
    prep();
    poke(0, 903);
    startRun();
    waitDone();
    chk("R11 code 903", int'(errCode), 3);
    chk("R11 count 0", int'(instrCount), 0);
    prep();
    poke(0, 900);
    startRun();
    waitDone();
    chk("R11 code 900", int'(errCode), 3);
    prep();
    poke(0, 401); poke(1, -5);
    startRun();
    waitDone();
    chk("R11 negative word", int'(errCode), 3);
    chk("R11 R12 count 1", int'(instrCount), 1);
    prep();
    poke(0, 1005);
    startRun();
    waitDone();
    chk("R11 word above 999", int'(errCode), 3);
  endtask

  task automatic t_restart();
    // previous run ended in error; a new start clears it
    prep();
    poke(0, 402); poke(1, 0);
    startRun();
    chk("R2 running after start", int'(running), 1);
    chk("R2 errCode cleared", int'(errCode), 0);
    waitDone();
    chk("R2 R12 fresh count", int'(instrCount), 2);
  endtask

  task automatic t_preload_ignored();
    prep();
    poke(0, 901); poke(1, 902); poke(2, 0);
    inQ[0] = 3; inCnt = 1; inEnable = 1'b0;
    startRun();
    repeat (8) @(negedge clk);
    chk("R6 stalled on input", int'(inReady), 1);
    poke(2, 902);
    inEnable = 1'b1;
    waitDone();
    chk("R13 preload ignored outputs", outN, 1);
    chk("R13 value", outQ[0], 3);
    chk("R13 halted at 02", int'(halted), 1);
    chk("R13 R12 count", int'(instrCount), 3);
  endtask

  task automatic t_backpressure();
    prep();
    poke(0, 510); poke(1, 902); poke(2, 0); poke(10, 77);
    outReady = 1'b0;
    startRun();
    repeat (12) @(negedge clk);
    chk("R7 outValid held", int'(outValid), 1);
    chk("R7 outData", int'(outData), 77);
    chk("R12 count stalled", int'(instrCount), 1);
    repeat (3) @(negedge clk);
    chk("R7 outData stable", int'(outData), 77);
    outReady = 1'b1;
    waitDone();
    chk("R7 taken once", outN, 1);
    chk("R12 count after out", int'(instrCount), 3);
  endtask

  task automatic t_halt_req();
    prep();
    poke(0, 600);
    startRun();
    repeat (20) @(negedge clk);
    haltReq = 1'b1;
    waitDone();
    haltReq = 1'b0;
    chk("R14 halted", int'(halted), 1);
    chk("R14 errCode", int'(errCode), 0);
    chk("R14 counted loop", int'(instrCount > 0), 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_add();
    t_diff(5, 9, 8);
    t_diff(9, 5, 10);
    t_branch();
    t_store_neg();
    t_data_err();
    t_pc_err();
    t_undef();
    t_restart();
    t_preload_ignored();
    t_backpressure();
    t_halt_req();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule